// File: doc/BRIEF.md
# Port Option and Strobe Pin-Mux Unit

This unit is a small special-function-register peripheral for an 8051-style microcontroller. It holds three registers: a port-options register, an auxiliary register and the latch of an extra general-purpose port. From these it drives the per-pin configuration of the chip's I/O. It selects whether the low address/data port runs open-drain or with weak pull-ups. It enables high-sink drive, one pin at a time, on the upper nibble of a second port. It can also hand the address-latch-enable and program-store-enable pins over to two bits of the extra port, so that they work as general-purpose I/O.

The core reaches the registers through a plain SFR bus: an address, write data, a write strobe and combinational read data. The core's own ALE and PSEN strobes pass through the unit on their way to the pads. When the matching enable bit is set, the port latch bit replaces the strobe on the pad. ALE keeps pulsing until either its hand-over bit or a quiet bit in the auxiliary register is set, so software can silence it before taking the pin over.

Top module: `port_cfg_mux`

## Requirements
- R1: After a synchronous active-low reset the options register (address 86H) and the auxiliary register (address 8EH) read 00H. The extra-port register (address D8H) reads 6FH, with all its used latch bits at 1. The pull-up and high-sink outputs are 0, and both strobe pads follow the core strobes.
- R2: Bit 0 of the options register drives `p0_pullup_o`. 0 means the low port is open-drain; 1 means it is quasi-bidirectional with a weak pull-up.
- R3: Options bits 1..4 each enable high-sink drive on one pin, independently. `p3_hisink_o[k]` equals options bit k+1, so bit 1 controls pin 4 and bit 4 controls pin 7.
- R4: Unused bits read 0, and writes to them are ignored. These are options bit 5, extra-port bits 4 and 7, and auxiliary bits 7..1.
- R5: With options bit 6 clear and auxiliary bit 0 clear, `ale_pad_o` equals `core_ale_i` in the same cycle.
- R6: With options bit 6 clear and auxiliary bit 0 set, `ale_pad_o` is held at 0. With options bit 6 set, `ale_pad_o` equals extra-port latch bit 5.
- R7: With options bit 7 clear, `psen_pad_o` equals `core_psen_n_i`. With it set, `psen_pad_o` equals extra-port latch bit 6. `strobe_gpio_o` is {options bit 7, options bit 6}.
- R8: A read of the extra port returns the pad level `p4_pin_i[0]` in bit 5 while options bit 6 is set, and latch bit 5 otherwise. Bit 6 likewise returns `p4_pin_i[1]` while options bit 7 is set, and latch bit 6 otherwise.
- R9: Extra-port latch bits 3..0 drive `p4_low_o[3:0]`.
- R10: A write to an address that is none of 86H, D8H or 8EH changes no register, and reads of such addresses return 00H.
- R11: A write takes effect at the clock edge where `sfr_we` is high. Without `sfr_we`, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | SFR address for reads and writes |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | SFR write strobe |
| sfr_rdata | output | 8 | Combinational read data for `sfr_addr` |
| core_ale_i | input | 1 | Address-latch-enable strobe from the core |
| core_psen_n_i | input | 1 | Active-low program-store-enable strobe from the core |
| p4_pin_i | input | 2 | Pad levels of the ALE pin (bit 0) and the PSEN pin (bit 1) |
| p0_pullup_o | output | 1 | Low port weak pull-up enable |
| p3_hisink_o | output | 4 | High-sink enables for pins 4..7 |
| p4_low_o | output | 4 | Extra-port latch bits 3..0 |
| ale_pad_o | output | 1 | Value driven on the ALE pad |
| psen_pad_o | output | 1 | Value driven on the PSEN pad |
| strobe_gpio_o | output | 2 | Pad mode: bit 0 ALE pin is GPIO, bit 1 PSEN pin is GPIO |

## Verification
The bench writes all ones to every register. A design that failed to mask the unused bits would then read back 1s in bits 5, 4 or 7. It also checks that ALE stops pulsing once the quiet bit is set while the pin is still owned by the core. A design that ignored that bit would keep copying the core strobe. It reads the extra port with the pad level set opposite to the latch, both with the hand-over enabled and with it disabled; swapping pin and latch would show up as an inverted bit. Finally, it applies write data with the strobe low, and to an unmapped address, to catch a decoder that writes without the strobe or aliases addresses.

// File: rtl/pcm_pkg.sv
// Package: shared addresses, field positions, masks and reset values for
// the port option and strobe pin-mux unit.
// Assumes an 8-bit SFR address and data bus.
package pcm_pkg;
    localparam int SFR_AW = 8;
    localparam int SFR_DW = 8;
    localparam int HS_W   = 4;   // high-sink pins on the upper nibble
    localparam int P4LO_W = 4;   // general-purpose low bits of extra port
    localparam int NSTB   = 2;   // strobe pins that can be handed over

    localparam logic [SFR_AW-1:0] OPT_ADDR_D = 8'h86;
    localparam logic [SFR_AW-1:0] XP_ADDR_D  = 8'hD8;
    localparam logic [SFR_AW-1:0] AUX_ADDR_D = 8'h8E;

    // options register fields
    localparam int OPT_PUP  = 0;
    localparam int OPT_HS0  = 1;
    localparam int OPT_EP5  = 6;
    localparam int OPT_EP6  = 7;
    // extra-port fields
    localparam int XP_B5    = 5;
    localparam int XP_B6    = 6;
    // auxiliary register field
    localparam int AUX_QUIET = 0;

    localparam logic [SFR_DW-1:0] OPT_MASK = 8'hDF;
    localparam logic [SFR_DW-1:0] XP_MASK  = 8'h6F;
    localparam logic [SFR_DW-1:0] AUX_MASK = 8'h01;
    localparam logic [SFR_DW-1:0] OPT_RST  = 8'h00;
    localparam logic [SFR_DW-1:0] XP_RST   = 8'h6F;
    localparam logic [SFR_DW-1:0] AUX_RST  = 8'h00;
endpackage

// File: rtl/pcm_sfr_reg.sv
// Module: one SFR-mapped register with a fixed address, a writable-bit
// mask and a reset value. Bits outside the mask stay 0 forever.
// Assumes a write is a single-cycle strobe sampled at the clock edge.
module pcm_sfr_reg #(
    parameter int                AW   = 8,
    parameter int                DW   = 8,
    parameter logic [AW-1:0]     ADDR = '0,
    parameter logic [DW-1:0]     MASK = '1,
    parameter logic [DW-1:0]     RSTV = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    output logic          hit,
    output logic [DW-1:0] q
);
    // address decode for this register
    always_comb hit = (addr == ADDR);

    // register update: reset value, or masked write data on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RSTV & MASK;
        else if (we && hit)
            q <= wdata & MASK;
    end
endmodule

// File: rtl/pcm_strobe_sel.sv
// Module: selects what one strobe pad drives. Either the core strobe
// (optionally forced quiet) or a port latch bit. Also gives the bit a
// port read returns: the pad level when handed over, the latch otherwise.
// Assumes pad_lvl is already synchronised by the pad ring.
module pcm_strobe_sel (
    input  logic gpio_en,
    input  logic core_strobe,
    input  logic quiet,
    input  logic quiet_lvl,
    input  logic latch_bit,
    input  logic pad_lvl,
    output logic pad_o,
    output logic rd_bit
);
    // pad drive selection
    always_comb begin
        if (gpio_en)
            pad_o = latch_bit;
        else if (quiet)
            pad_o = quiet_lvl;
        else
            pad_o = core_strobe;
    end

    // read-back selection for the port bit
    always_comb rd_bit = gpio_en ? pad_lvl : latch_bit;
endmodule

// File: rtl/port_cfg_mux.sv
// Module: port option and strobe pin-mux unit (top).
// Holds the options, auxiliary and extra-port registers. Drives the
// pull-up and high-sink enables and muxes the ALE/PSEN pads between the
// core strobes and extra-port bits 5/6. Reads are combinational.
// Assumes one SFR access per cycle and a synchronous active-low reset.
module port_cfg_mux
    import pcm_pkg::*;
#(
    parameter logic [SFR_AW-1:0] OPT_ADDR = OPT_ADDR_D,
    parameter logic [SFR_AW-1:0] XP_ADDR  = XP_ADDR_D,
    parameter logic [SFR_AW-1:0] AUX_ADDR = AUX_ADDR_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SFR_AW-1:0] sfr_addr,
    input  logic [SFR_DW-1:0] sfr_wdata,
    input  logic              sfr_we,
    output logic [SFR_DW-1:0] sfr_rdata,
    input  logic              core_ale_i,
    input  logic              core_psen_n_i,
    input  logic [NSTB-1:0]   p4_pin_i,
    output logic              p0_pullup_o,
    output logic [HS_W-1:0]   p3_hisink_o,
    output logic [P4LO_W-1:0] p4_low_o,
    output logic              ale_pad_o,
    output logic              psen_pad_o,
    output logic [NSTB-1:0]   strobe_gpio_o
);
    localparam int NREG = 3;
    localparam logic [NREG*SFR_AW-1:0] ADDRS = {AUX_ADDR, XP_ADDR, OPT_ADDR};
    localparam logic [NREG*SFR_DW-1:0] MASKS = {AUX_MASK, XP_MASK, OPT_MASK};
    localparam logic [NREG*SFR_DW-1:0] RSTS  = {AUX_RST, XP_RST, OPT_RST};

    logic [SFR_DW-1:0] reg_q [NREG];
    logic [NREG-1:0]   reg_hit;
    logic [SFR_DW-1:0] opt_q, xp_q, aux_q;

    // register bank: one instance per mapped register
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        pcm_sfr_reg #(
            .AW  (SFR_AW),
            .DW  (SFR_DW),
            .ADDR(ADDRS[r*SFR_AW +: SFR_AW]),
            .MASK(MASKS[r*SFR_DW +: SFR_DW]),
            .RSTV(RSTS[r*SFR_DW +: SFR_DW])
        ) u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .addr (sfr_addr),
            .wdata(sfr_wdata),
            .we   (sfr_we),
            .hit  (reg_hit[r]),
            .q    (reg_q[r])
        );
    end

    // named views of the bank
    always_comb begin
        opt_q = reg_q[0];
        xp_q  = reg_q[1];
        aux_q = reg_q[2];
    end

    // static pin configuration outputs
    always_comb begin
        p0_pullup_o   = opt_q[OPT_PUP];
        p3_hisink_o   = opt_q[OPT_HS0 +: HS_W];
        p4_low_o      = xp_q[P4LO_W-1:0];
        strobe_gpio_o = {opt_q[OPT_EP6], opt_q[OPT_EP5]};
    end

    // per-strobe selection inputs, index 0 = ALE, 1 = PSEN
    logic [NSTB-1:0] stb_core, stb_quiet, stb_qlvl, stb_latch, stb_pad, stb_rd;
    always_comb begin
        stb_core  = {core_psen_n_i, core_ale_i};
        stb_quiet = {1'b0, aux_q[AUX_QUIET]};
        stb_qlvl  = {1'b1, 1'b0};
        stb_latch = {xp_q[XP_B6], xp_q[XP_B5]};
    end

    // strobe pad muxes
    for (genvar s = 0; s < NSTB; s++) begin : g_stb
        pcm_strobe_sel u_sel (
            .gpio_en    (strobe_gpio_o[s]),
            .core_strobe(stb_core[s]),
            .quiet      (stb_quiet[s]),
            .quiet_lvl  (stb_qlvl[s]),
            .latch_bit  (stb_latch[s]),
            .pad_lvl    (p4_pin_i[s]),
            .pad_o      (stb_pad[s]),
            .rd_bit     (stb_rd[s])
        );
    end

    // pad outputs
    always_comb begin
        ale_pad_o  = stb_pad[0];
        psen_pad_o = stb_pad[1];
    end

    // combinational read mux
    always_comb begin
        sfr_rdata = '0;
        if (reg_hit[0])
            sfr_rdata = opt_q;
        else if (reg_hit[1])
            sfr_rdata = {xp_q[7], stb_rd[1], stb_rd[0], xp_q[4:0]};
        else if (reg_hit[2])
            sfr_rdata = aux_q;
    end
endmodule

// File: rtl/port_cfg_mux_chk.sv
// Module: assertion checker for port_cfg_mux, attached with bind.
// Assumes the internal register views opt_q, xp_q and aux_q.
module port_cfg_mux_chk
    import pcm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [SFR_AW-1:0] sfr_addr,
    input logic [SFR_DW-1:0] sfr_wdata,
    input logic              sfr_we,
    input logic              core_ale_i,
    input logic              core_psen_n_i,
    input logic              p0_pullup_o,
    input logic [HS_W-1:0]   p3_hisink_o,
    input logic              ale_pad_o,
    input logic              psen_pad_o,
    input logic [SFR_DW-1:0] opt_q,
    input logic [SFR_DW-1:0] xp_q,
    input logic [SFR_DW-1:0] aux_q
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (opt_q == 8'h00 && aux_q == 8'h00 && xp_q == 8'h6F));

    a_r2_pullup_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_we && sfr_addr == OPT_ADDR_D) |=> p0_pullup_o == $past(sfr_wdata[OPT_PUP]));

    a_r3_hisink_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_we && sfr_addr == OPT_ADDR_D) |=> p3_hisink_o == $past(sfr_wdata[4:1]));

    a_r4_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_q[5] == 1'b0 && xp_q[4] == 1'b0 && xp_q[7] == 1'b0 && aux_q[7:1] == 7'd0));

    a_r5_ale_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!opt_q[OPT_EP5] && !aux_q[AUX_QUIET]) |-> ale_pad_o == core_ale_i);

    a_r6_ale_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!opt_q[OPT_EP5] && aux_q[AUX_QUIET]) |-> !ale_pad_o);

    a_r6_ale_gpio: assert property (@(posedge clk) disable iff (!rst_n)
        opt_q[OPT_EP5] |-> ale_pad_o == xp_q[XP_B5]);

    a_r7_psen_core: assert property (@(posedge clk) disable iff (!rst_n)
        !opt_q[OPT_EP6] |-> psen_pad_o == core_psen_n_i);

    a_r7_psen_gpio: assert property (@(posedge clk) disable iff (!rst_n)
        opt_q[OPT_EP6] |-> psen_pad_o == xp_q[XP_B6]);

    a_r11_hold_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        !sfr_we |=> ($stable(opt_q) && $stable(xp_q) && $stable(aux_q)));
endmodule

bind port_cfg_mux port_cfg_mux_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sfr_addr     (sfr_addr),
    .sfr_wdata    (sfr_wdata),
    .sfr_we       (sfr_we),
    .core_ale_i   (core_ale_i),
    .core_psen_n_i(core_psen_n_i),
    .p0_pullup_o  (p0_pullup_o),
    .p3_hisink_o  (p3_hisink_o),
    .ale_pad_o    (ale_pad_o),
    .psen_pad_o   (psen_pad_o),
    .opt_q        (opt_q),
    .xp_q         (xp_q),
    .aux_q        (aux_q)
);

// File: tb/test_port_cfg_mux.sv
// Bench: scoreboard for port_cfg_mux. The driver keeps a shadow model
// built from the requirements, pushes expected items into a queue and
// signals a monitor that pops and compares them against the outputs.
module test_port_cfg_mux;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_OPT = 8'h86;
    localparam logic [7:0] A_XP  = 8'hD8;
    localparam logic [7:0] A_AUX = 8'h8E;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = '0, sfr_wdata = '0, sfr_rdata;
    logic       sfr_we = 1'b0;
    logic       core_ale_i = 1'b0, core_psen_n_i = 1'b1;
    logic [1:0] p4_pin_i = 2'b00;
    logic       p0_pullup_o, ale_pad_o, psen_pad_o;
    logic [3:0] p3_hisink_o, p4_low_o;
    logic [1:0] strobe_gpio_o;

    port_cfg_mux i_port_cfg_mux (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .core_ale_i(core_ale_i),
        .core_psen_n_i(core_psen_n_i), .p4_pin_i(p4_pin_i),
        .p0_pullup_o(p0_pullup_o), .p3_hisink_o(p3_hisink_o),
        .p4_low_o(p4_low_o), .ale_pad_o(ale_pad_o), .psen_pad_o(psen_pad_o),
        .strobe_gpio_o(strobe_gpio_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        string      tag;
        logic [7:0] rdata;
        logic       pup;
        logic [3:0] hs;
        logic [3:0] p4lo;
        logic       ale;
        logic       psen;
        logic [1:0] gpio;
    } exp_t;

    exp_t q[$];
    event mon_ev;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 0;

    // shadow model of the registers
    logic [7:0] m_opt = 8'h00, m_xp = 8'h6F, m_aux = 8'h00;

    // monitor: pop expected items and compare with the outputs
    initial begin
        forever begin
            @(mon_ev);
            while (q.size() > 0) begin
                exp_t e;
                logic [25:0] act, exv;
                e = q.pop_front();
                act = {sfr_rdata, p0_pullup_o, p3_hisink_o, p4_low_o, ale_pad_o, psen_pad_o, strobe_gpio_o, 3'b0};
                exv = {e.rdata, e.pup, e.hs, e.p4lo, e.ale, e.psen, e.gpio, 3'b0};
                n_vec++;
                if (act !== exv) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%h pup=%b hs=%b p4lo=%b ale=%b psen=%b gpio=%b expected rdata=%h pup=%b hs=%b p4lo=%b ale=%b psen=%b gpio=%b",
                             e.tag, sfr_rdata, p0_pullup_o, p3_hisink_o, p4_low_o, ale_pad_o, psen_pad_o, strobe_gpio_o,
                             e.rdata, e.pup, e.hs, e.p4lo, e.ale, e.psen, e.gpio);
                end
            end
        end
    end

    // driver: expected read value of an address from the model
    function automatic logic [7:0] exp_read(logic [7:0] a);
        logic b5, b6;
        b5 = m_opt[6] ? p4_pin_i[0] : m_xp[5];
        b6 = m_opt[7] ? p4_pin_i[1] : m_xp[6];
        case (a)
            A_OPT:   return m_opt;
            A_XP:    return {1'b0, b6, b5, 1'b0, m_xp[3:0]};
            A_AUX:   return m_aux;
            default: return 8'h00;
        endcase
    endfunction

    // driver: set stimulus mid-cycle, push the expected item, wake monitor
    task automatic probe(string tag, logic [7:0] a, logic ale, logic psen_n, logic [1:0] pins);
        exp_t e;
        @(negedge clk);
        sfr_addr = a; core_ale_i = ale; core_psen_n_i = psen_n; p4_pin_i = pins;
        #1;
        e.tag   = tag;
        e.rdata = exp_read(a);
        e.pup   = m_opt[0];
        e.hs    = m_opt[4:1];
        e.p4lo  = m_xp[3:0];
        e.ale   = m_opt[6] ? m_xp[5] : (m_aux[0] ? 1'b0 : ale);
        e.psen  = m_opt[7] ? m_xp[6] : psen_n;
        e.gpio  = {m_opt[7], m_opt[6]};
        q.push_back(e);
        ->mon_ev;
        #1;
    endtask

    // driver: one bus cycle; the model updates only when the strobe is high
    task automatic bus_wr(logic [7:0] a, logic [7:0] d, logic we);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_we = we;
        @(posedge clk);
        if (we) begin
            if (a == A_OPT) m_opt = d & 8'hDF;
            else if (a == A_XP) m_xp = d & 8'h6F;
            else if (a == A_AUX) m_aux = d & 8'h01;
        end
        #1 sfr_we = 1'b0;
    endtask

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // stimulus
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state of every register and output
        probe("R1 opt reset", A_OPT, 1'b1, 1'b0, 2'b00);
        probe("R1 xp reset", A_XP, 1'b0, 1'b1, 2'b00);
        probe("R1 aux reset", A_AUX, 1'b1, 1'b1, 2'b00);
        // R2 pull-up enable
        bus_wr(A_OPT, 8'h01, 1'b1);
        probe("R2 pullup on", A_OPT, 1'b0, 1'b1, 2'b00);
        // R3 high-sink bits, full and alternating patterns
        bus_wr(A_OPT, 8'h1E, 1'b1);
        probe("R3 hisink all", A_OPT, 1'b0, 1'b1, 2'b00);
        bus_wr(A_OPT, 8'h0A, 1'b1);
        probe("R3 hisink 0101", A_OPT, 1'b0, 1'b1, 2'b00);
        bus_wr(A_OPT, 8'h12, 1'b1);
        probe("R3 hisink 1001", A_OPT, 1'b0, 1'b1, 2'b00);
        // R9 low extra-port bits, R4 unused extra-port bits
        bus_wr(A_XP, 8'hFA, 1'b1);
        probe("R9 p4 low bits / R4 xp unused", A_XP, 1'b1, 1'b0, 2'b00);
        bus_wr(A_XP, 8'h05, 1'b1);
        probe("R9 p4 low 0101", A_XP, 1'b1, 1'b0, 2'b11);
        // R5 ALE follows the core, both levels
        probe("R5 ale high", A_OPT, 1'b1, 1'b1, 2'b00);
        probe("R5 ale low", A_OPT, 1'b0, 1'b1, 2'b00);
        // R6 quiet bit holds ALE low; R4 aux unused bits
        bus_wr(A_AUX, 8'hFF, 1'b1);
        probe("R6 ale quiet / R4 aux unused", A_AUX, 1'b1, 1'b1, 2'b00);
        probe("R6 ale quiet core low", A_OPT, 1'b0, 1'b1, 2'b00);
        // R4 options bit 5 and R6/R7 hand-over of both strobes
        bus_wr(A_XP, 8'h20, 1'b1);
        bus_wr(A_OPT, 8'hFF, 1'b1);
        probe("R4 opt unused / R6 ale gpio", A_OPT, 1'b0, 1'b0, 2'b00);
        probe("R7 psen gpio", A_OPT, 1'b1, 1'b1, 2'b01);
        // R8 read of handed-over bits returns the pad level
        probe("R8 pin read 01", A_XP, 1'b0, 1'b0, 2'b01);
        probe("R8 pin read 10", A_XP, 1'b0, 1'b0, 2'b10);
        bus_wr(A_XP, 8'h40, 1'b1);
        probe("R6 R7 latch swap", A_OPT, 1'b1, 1'b1, 2'b00);
        // R8 with hand-over off, latch is returned; R7 psen follows core
        bus_wr(A_OPT, 8'h00, 1'b1);
        bus_wr(A_AUX, 8'h00, 1'b1);
        probe("R8 latch read pins 11", A_XP, 1'b1, 1'b0, 2'b11);
        probe("R7 psen core", A_OPT, 1'b1, 1'b0, 2'b11);
        // R10 unmapped write and read
        bus_wr(8'h00, 8'hFF, 1'b1);
        bus_wr(8'h87, 8'hFF, 1'b1);
        probe("R10 unmapped read", 8'h00, 1'b0, 1'b1, 2'b00);
        probe("R10 opt untouched", A_OPT, 1'b0, 1'b1, 2'b00);
        probe("R10 xp untouched", A_XP, 1'b0, 1'b1, 2'b00);
        // R11 no strobe, no change
        bus_wr(A_OPT, 8'hDF, 1'b0);
        bus_wr(A_XP, 8'hFF, 1'b0);
        probe("R11 opt held without we", A_OPT, 1'b0, 1'b1, 2'b00);
        probe("R11 xp held without we", A_XP, 1'b0, 1'b1, 2'b00);
        // R1 reset again returns everything to reset values
        bus_wr(A_OPT, 8'hC1, 1'b1);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        m_opt = 8'h00; m_xp = 8'h6F; m_aux = 8'h00;
        probe("R1 reset after use", A_XP, 1'b1, 1'b0, 2'b00);
        repeat (2) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule